// File: doc/BRIEF.md
# Digital IF-to-Quadrature Splitter

This block turns a real, two's-complement sample stream into in-phase (I) and quadrature (Q) components. One input sample is taken on every clock, and the wanted signal sits at three quarters of the sample rate. The input is first down-mixed by a four-step sign-and-zero pattern, so no multipliers are needed. Each branch is then low-pass filtered by a half-band FIR and decimated by two. A single filter datapath is shared between the branches: it serves I on one clock and Q on the next.

The results leave on one 8-bit bus, with I and Q on alternate clocks. A select output marks which component the word holds. A mode input keeps the output at baseband or moves it to a quarter of the input sample rate. It does this by negating every second I/Q pair, which turns the complex stream by a half turn per pair, or a quarter turn per output word.

Top module: `iqsplit_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `iqWord` = 0 and `iqSel` = 0, and both filter delay lines are cleared. After release, outputs depend only on samples taken after reset.
- R2: Number the edges from e = 0, the first edge with `rst` low. After edge e, `iqSel` equals e mod 2, where 0 means I and 1 means Q. The first word after reset is therefore I.
- R3: The mixed I value at edge e is x, 0, -x, 0 for e mod 4 = 0, 1, 2, 3. The mixed Q value is 0, x, 0, -x. Negation saturates, so -(-128) gives +127 and a negated value is never -128.
- R4: Each branch is filtered with the taps (-1, 0, 9, 16, 9, 0, -1): y[e] = sum over k of c[k]·m[e-k]. The current sample feeds tap 0, and samples from before reset release count as zero.
- R5: The filter sum S is rounded as floor((S+16)/32) and clamped to [-128, 127]. For this tap set no output word is ever -128.
- R6: With `ifMode` = 0, the word after edge e is the I result y_I[e] when e is even and the Q result y_Q[e] when e is odd.
- R7: With `ifMode` = 1, words from edges with e mod 4 in {2, 3} are the saturating negation of the R6 value. Words from edges with e mod 4 in {0, 1} are unchanged.
- R8: `ifMode` is read at every edge. Changing it takes effect on the next output word, and it neither restarts the phase sequence nor disturbs the filter state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one input sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 8 | Real input sample, two's complement |
| ifMode | input | 1 | 0: baseband output, 1: output centred at a quarter of the sample rate |
| iqWord | output | 8 | Time-multiplexed I/Q result, two's complement |
| iqSel | output | 1 | Component marker for `iqWord`: 0 = I, 1 = Q |

## Verification
A phase counter that is off by one swaps the I and Q slots. It also flips the mixer signs, which shows as a wrong `iqSel` on the first word after reset, or as wrong values within four clocks of any non-zero input. A delay-line tap that holds stale state, or is not cleared on reset, puts energy on `iqWord` for up to six words after a reset that is followed by an isolated impulse. An error in rounding or in the IF-mode negation shows on the very word it affects, so impulses of ±16 and tones in both modes expose such a fault at once.

// File: rtl/iqsplit_pkg.sv
package iqsplit_pkg;

  // Length of the half-band impulse response.
  localparam int NUM_TAPS = 7;

  // Strobes from the phase controller to the datapath.
  typedef struct packed {
    logic pickQ;  // odd phase: the shared filter serves the Q branch
    logic negI;   // phase 2: the I mix is the negated sample
    logic negQ;   // phase 3: the Q mix is the negated sample
    logic flip;   // phases 2 and 3: the second pair of the IF rotation
  } ctrlStrobe_t;

  // Symmetric half-band taps, which sum to 32.
  function automatic int tapCoef(input int idx);
    case (idx)
      0, 6:    tapCoef = -1;
      2, 4:    tapCoef = 9;
      3:       tapCoef = 16;
      default: tapCoef = 0;
    endcase
  endfunction

endpackage

// File: rtl/iqsplit_ctrl.sv
module iqsplit_ctrl
  import iqsplit_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output ctrlStrobe_t strobe
);

  // Four-step carrier phase. It also sets the I/Q slot and the IF pair parity.
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 2'd0;
    else     phase <= phase + 2'd1;
  end

  always_comb begin
    strobe.pickQ = phase[0];
    strobe.negI  = (phase == 2'd2);
    strobe.negQ  = (phase == 2'd3);
    strobe.flip  = phase[1];
  end

  // A negate strobe must always fall in its own branch's slot.
  p_neg_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.negI |-> !strobe.pickQ) and (strobe.negQ |-> strobe.pickQ));

endmodule

// File: rtl/iqsplit_datapath.sv
module iqsplit_datapath
  import iqsplit_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 16,
  parameter int COEF_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              ifMode,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] wordOut,
  output logic              selOut
);

  localparam int LINE_LEN = NUM_TAPS - 1;
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0]  HALF_LSB = ACC_W'(1 << (COEF_SHIFT - 1));

  function automatic logic signed [DATA_W-1:0] satNeg(input logic signed [DATA_W-1:0] v);
    return (v == MIN_V) ? MAX_V : -v;
  endfunction

  // ---------------- multiplier-free down-mix ----------------
  logic signed [DATA_W-1:0] din;
  logic signed [DATA_W-1:0] mixI, mixQ;

  assign din = $signed(sampleIn);

  always_comb begin
    mixI = strobe.pickQ ? '0 : (strobe.negI ? satNeg(din) : din);
    mixQ = strobe.pickQ ? (strobe.negQ ? satNeg(din) : din) : '0;
  end

  p_neg_range_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.negI |-> mixI != MIN_V) and (strobe.negQ |-> mixQ != MIN_V));

  // ---------------- per-branch delay lines ----------------
  for (genvar b = 0; b < 2; b++) begin : g_branch
    logic signed [DATA_W-1:0] feed;
    logic signed [DATA_W-1:0] line [LINE_LEN];
    logic signed [DATA_W-1:0] taps [NUM_TAPS];

    assign feed = (b == 0) ? mixI : mixQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < LINE_LEN; k++) line[k] <= '0;
      end else begin
        line[0] <= feed;
        for (int k = 1; k < LINE_LEN; k++) line[k] <= line[k-1];
      end
    end

    always_comb begin
      taps[0] = feed;
      for (int k = 1; k < NUM_TAPS; k++) taps[k] = line[k-1];
    end

    p_line_clear_r1: assert property (@(posedge clk)
      rst |=> (line[0] == '0 && line[LINE_LEN-1] == '0));
  end

  // ---------------- shared half-band filter ----------------
  logic signed [DATA_W-1:0] tapSel [NUM_TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [DATA_W-1:0] clamped;
  logic signed [DATA_W-1:0] shaped;

  always_comb begin
    for (int k = 0; k < NUM_TAPS; k++)
      tapSel[k] = strobe.pickQ ? g_branch[1].taps[k] : g_branch[0].taps[k];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++)
      acc = acc + ACC_W'(tapCoef(k) * int'(tapSel[k]));
  end

  always_comb begin
    rounded = (acc + HALF_LSB) >>> COEF_SHIFT;
    if (rounded > ACC_W'(MAX_V))      clamped = MAX_V;
    else if (rounded < ACC_W'(MIN_V)) clamped = MIN_V;
    else                              clamped = rounded[DATA_W-1:0];
  end

  // IF re-centring: negate every second I/Q pair.
  assign shaped = (ifMode && strobe.flip) ? satNeg(clamped) : clamped;

  // ---------------- output register ----------------
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      wordOut <= '0;
      selOut  <= 1'b0;
      primed  <= 1'b0;
    end else begin
      wordOut <= shaped;
      selOut  <= strobe.pickQ;
      primed  <= 1'b1;
    end
  end

  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> (wordOut == '0 && selOut == 1'b0));

  p_q_after_i_r2: assert property (@(posedge clk) disable iff (rst)
    (primed && !selOut) |=> selOut);

  p_i_after_q_r2: assert property (@(posedge clk) disable iff (rst)
    selOut |=> !selOut);

  p_no_min_word_r5: assert property (@(posedge clk) disable iff (rst)
    $signed(wordOut) != MIN_V);

endmodule

// File: rtl/iqsplit_top.sv
module iqsplit_top
  import iqsplit_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 16,
  parameter int COEF_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              ifMode,
  output logic [DATA_W-1:0] iqWord,
  output logic              iqSel
);

  ctrlStrobe_t strobe;

  iqsplit_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  iqsplit_datapath #(
    .DATA_W     (DATA_W),
    .ACC_W      (ACC_W),
    .COEF_SHIFT (COEF_SHIFT)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .ifMode   (ifMode),
    .strobe   (strobe),
    .wordOut  (iqWord),
    .selOut   (iqSel)
  );

endmodule

// File: tb/tb_iqsplit_top.sv
module tb_iqsplit_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sampleIn = 8'd0;
  logic       ifMode = 1'b0;
  logic [7:0] iqWord;
  logic       iqSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iqsplit_top dut (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .ifMode   (ifMode),
    .iqWord   (iqWord),
    .iqSel    (iqSel)
  );

  typedef struct {
    int    word;
    int    sel;
    string tag;
  } item_t;

  item_t expQ[$];

  // Reference model state, derived from the requirements.
  int coef[7] = '{-1, 0, 9, 16, 9, 0, -1};
  int histI[7];
  int histQ[7];
  int edgeNo;

  function automatic int negSat(input int v);
    return (v == -128) ? 127 : -v;
  endfunction

  task automatic modelClear();
    for (int k = 0; k < 7; k++) begin
      histI[k] = 0;
      histQ[k] = 0;
    end
    edgeNo = 0;
  endtask

  // Driver: apply one sample and push the word expected after the next edge.
  task automatic pushSample(input int x, input bit md, input string tag);
    item_t it;
    int p, mI, mQ, s, y;
    @(negedge clk);
    sampleIn = 8'(x);
    ifMode = md;
    p = edgeNo % 4;
    // R3 mixing patterns
    mI = (p == 0) ? x : (p == 2) ? negSat(x) : 0;
    mQ = (p == 1) ? x : (p == 3) ? negSat(x) : 0;
    for (int k = 6; k > 0; k--) begin
      histI[k] = histI[k-1];
      histQ[k] = histQ[k-1];
    end
    histI[0] = mI;
    histQ[0] = mQ;
    // R4 filter, R6 slot choice
    s = 0;
    for (int k = 0; k < 7; k++)
      s += coef[k] * ((edgeNo % 2 == 0) ? histI[k] : histQ[k]);
    // R5 rounding and clamp
    y = (s + 16) >>> 5;
    if (y > 127) y = 127;
    if (y < -128) y = -128;
    // R7 IF negation on the second pair
    if (md && p >= 2) y = negSat(y);
    it.word = y;
    it.sel = edgeNo % 2;
    it.tag = tag;
    edgeNo++;
    @(posedge clk);
    expQ.push_back(it);
  endtask

  // Monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if ($signed(iqWord) != it.word || int'(iqSel) != it.sel) begin
          failures++;
          $display("FAIL %s: word=%0d sel=%0d expected word=%0d sel=%0d",
                   it.tag, $signed(iqWord), iqSel, it.word, it.sel);
        end
      end
    end
  end

  // R1: reset state check
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleIn = 8'h5A;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (iqWord !== 8'd0 || iqSel !== 1'b0) begin
      failures++;
      $display("FAIL R1: word=%0d sel=%0d expected word=0 sel=0", iqWord, iqSel);
    end
    modelClear();
    rst = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    modelClear();
    doReset();

    // R2: the first words after reset alternate I then Q
    pushSample(40, 1'b0, "R2");
    pushSample(-40, 1'b0, "R2");
    pushSample(0, 1'b0, "R2");
    pushSample(0, 1'b0, "R2");

    // R4: impulse response on the I branch
    doReset();
    pushSample(64, 1'b0, "R4");
    for (int i = 0; i < 10; i++) pushSample(0, 1'b0, "R4");

    // R3: impulse on the Q phase, then negated phases
    doReset();
    pushSample(0, 1'b0, "R3");
    pushSample(64, 1'b0, "R3");
    pushSample(0, 1'b0, "R3");
    pushSample(-64, 1'b0, "R3");
    for (int i = 0; i < 8; i++) pushSample(0, 1'b0, "R3");

    // R3: full-scale negative input exercises saturated negation
    for (int i = 0; i < 16; i++) pushSample(-128, 1'b0, "R3");

    // R5: half-LSB rounding of single impulses
    doReset();
    pushSample(16, 1'b0, "R5");
    for (int i = 0; i < 8; i++) pushSample(0, 1'b0, "R5");
    doReset();
    pushSample(-16, 1'b0, "R5");
    for (int i = 0; i < 8; i++) pushSample(0, 1'b0, "R5");

    // R6: carrier tone at three quarters of the rate gives a baseband DC value
    doReset();
    for (int i = 0; i < 24; i++)
      pushSample((i % 4 == 0) ? 100 : (i % 4 == 2) ? -100 : 0, 1'b0, "R6");

    // R7: same tone in IF mode
    doReset();
    for (int i = 0; i < 24; i++)
      pushSample((i % 4 == 0) ? 100 : (i % 4 == 2) ? -100 : 0, 1'b1, "R7");

    // R8: random samples with the mode switching mid-stream
    doReset();
    for (int i = 0; i < 240; i++)
      pushSample(int'($urandom_range(0, 255)) - 128, ((i / 7) % 2) == 1, "R8");

    // R1: reset mid-stream clears the delay lines
    for (int i = 0; i < 20; i++) pushSample(120, 1'b0, "R1");
    doReset();
    pushSample(32, 1'b0, "R1");
    for (int i = 0; i < 8; i++) pushSample(0, 1'b0, "R1");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule